// File: doc/BRIEF.md
# Serial Receive Character Buffer with Overrun Detection

This block sits between a serial deserializer and a CPU-side read port. Each time the deserializer finishes a character it presents the data bits together with three status flags: break seen, framing error and parity error. The block stores up to three such characters in a holding FIFO. When all three positions are taken, one more character can wait in a single-entry waiting stage that stands for the receiver shift register.

The CPU pops one character per read strobe and gets its data and flags. Three status outputs describe the buffer: `rx_ready` (at least one character is stored), `fifo_full` (all holding positions are occupied) and a sticky `overrun` flag. `overrun` is set when a character is lost because both the FIFO and the waiting stage were occupied. A clear-error strobe resets the sticky flag.

All outputs are registered. Read data appears the cycle after the read strobe. Status outputs change on the same clock edge that changes the FIFO contents.

Top module: `rxbuf_top`

## Requirements
- R1: The FIFO holds `DEPTH` (default 3) characters, each stored with its break, framing and parity flags. Reads return them oldest first with their own flags. `{rd_brk,rd_ferr,rd_perr,rd_data}` updates on the clock edge that samples `rd_en` high while the FIFO is not empty.
- R2: A character that arrives while the FIFO is full waits in the waiting stage. It moves into the FIFO in the same cycle that a read frees a position, and it is not lost.
- R3: A character that arrives while the FIFO is full and the waiting stage is occupied sets `overrun`. The waiting character and its flags are discarded, and the new character takes over the waiting stage.
- R4: `overrun` stays high through reads and clears only on a cycle with `clr_err` high. If an overrun event and `clr_err` fall in the same cycle, `overrun` ends up set.
- R5: `fifo_full` rises when a move into the FIFO occupies the last free position. It falls after a read frees a position, unless a waiting character refills that position in the same cycle.
- R6: `rx_ready` rises when a character enters the FIFO. It falls only when a read leaves the FIFO empty.
- R7: When a read and a move into the FIFO fall in the same cycle, the number of stored characters is unchanged and arrival order is kept.
- R8: A read strobe while the FIFO is empty leaves the read outputs at their last values and changes no status output.
- R9: Reset (`rst_n` low) empties the FIFO and the waiting stage, clears all three status outputs and sets the read outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_valid | input | 1 | One-cycle strobe: a received character is presented |
| char_data | input | DW | Received character bits |
| char_brk | input | 1 | Break flag of the received character |
| char_ferr | input | 1 | Framing-error flag of the received character |
| char_perr | input | 1 | Parity-error flag of the received character |
| rd_en | input | 1 | CPU read strobe, pops one character |
| rd_data | output | DW | Character bits of the last popped entry |
| rd_brk | output | 1 | Break flag of the last popped entry |
| rd_ferr | output | 1 | Framing-error flag of the last popped entry |
| rd_perr | output | 1 | Parity-error flag of the last popped entry |
| clr_err | input | 1 | Clear-error command, resets `overrun` |
| rx_ready | output | 1 | At least one character is stored |
| fifo_full | output | 1 | All FIFO positions are occupied |
| overrun | output | 1 | Sticky flag: a character was lost |

## Verification
The bench builds the block with its defaults: `DW` = 8 and `DEPTH` = 3. With these values, four back-to-back arrivals fill every position and the waiting stage, and a fifth arrival triggers the overrun. Each stored character carries a distinct flag pattern, so a swapped or dropped flag shows up in the popped value. That same setup lets the bench check a simultaneous read and arrival at full depth, a clear that collides with an overrun, and reads on an empty buffer.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int unsigned FLAG_W = 3;

  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rx_flags_t;
endpackage

// File: rtl/rxbuf_fifo.sv
module rxbuf_fifo #(
  parameter int unsigned EW    = 11,
  parameter int unsigned DEPTH = 3,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [EW-1:0] push_word,
  input  logic          pop,
  output logic [EW-1:0] rd_word,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt
);

  logic [EW-1:0] slot_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_nxt;
  logic [PW-1:0] rd_ptr_q, rd_ptr_nxt;
  logic [CW-1:0] cnt_q;
  logic [EW-1:0] rd_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_nxt = push ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_nxt = pop  ? bump(rd_ptr_q) : rd_ptr_q;
    cnt_nxt    = cnt_q;
    if (push && !pop)      cnt_nxt = cnt_q + 1'b1;
    else if (pop && !push) cnt_nxt = cnt_q - 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             slot_q[i] <= '0;
      else if (push && wr_ptr_q == PW'(i))    slot_q[i] <= push_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_nxt;
      rd_ptr_q <= rd_ptr_nxt;
      cnt_q    <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rd_q <= '0;
    else if (pop) rd_q <= slot_q[rd_ptr_q];
  end

  assign rd_word = rd_q;
  assign cnt     = cnt_q;

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  assert_order_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/rxbuf_hold.sv
module rxbuf_hold #(
  parameter int unsigned EW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          char_valid,
  input  logic [EW-1:0] char_word,
  input  logic          room,
  output logic          push,
  output logic [EW-1:0] push_word,
  output logic          hold_valid,
  output logic          ovr_evt
);

  logic          hv_q, hv_nxt;
  logic [EW-1:0] hw_q, hw_nxt;
  logic          hw_en;

  always_comb begin
    push      = 1'b0;
    push_word = char_word;
    hv_nxt    = hv_q;
    hw_nxt    = hw_q;
    ovr_evt   = 1'b0;
    if (hv_q) begin
      if (room) begin
        push      = 1'b1;
        push_word = hw_q;
        hv_nxt    = char_valid;
        hw_nxt    = char_word;
      end else if (char_valid) begin
        ovr_evt = 1'b1;
        hw_nxt  = char_word;
      end
    end else if (char_valid) begin
      if (room) begin
        push = 1'b1;
      end else begin
        hv_nxt = 1'b1;
        hw_nxt = char_word;
      end
    end
  end

  assign hw_en = char_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hv_q <= 1'b0;
    else        hv_q <= hv_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hw_q <= '0;
    else if (hw_en) hw_q <= hw_nxt;
  end

  assign hold_valid = hv_q;

  assert_hold_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_q && room) |-> push);

  assert_overrun_evt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> hv_q);

endmodule

// File: rtl/rxbuf_status.sv
module rxbuf_status #(
  parameter int unsigned DEPTH = 3,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          ovr_evt,
  input  logic          clr_err,
  output logic          rx_ready,
  output logic          fifo_full,
  output logic          overrun
);

  logic rdy_q, full_q, ovr_q;
  logic rdy_nxt, full_nxt, ovr_nxt;

  always_comb begin
    rdy_nxt  = (cnt_nxt != '0);
    full_nxt = (cnt_nxt == CW'(DEPTH));
    ovr_nxt  = ovr_q;
    if (clr_err) ovr_nxt = 1'b0;
    if (ovr_evt) ovr_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      rdy_q  <= rdy_nxt;
      full_q <= full_nxt;
      ovr_q  <= ovr_nxt;
    end
  end

  assign rx_ready  = rdy_q;
  assign fifo_full = full_q;
  assign overrun   = ovr_q;

  assert_sticky_ovr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !clr_err) |=> ovr_q);

  assert_ovr_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ovr_q);

  assert_full_has_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> rdy_q);

endmodule

// File: rtl/rxbuf_top.sv
module rxbuf_top
  import rxbuf_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          char_valid,
  input  logic [DW-1:0] char_data,
  input  logic          char_brk,
  input  logic          char_ferr,
  input  logic          char_perr,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_brk,
  output logic          rd_ferr,
  output logic          rd_perr,
  input  logic          clr_err,
  output logic          rx_ready,
  output logic          fifo_full,
  output logic          overrun
);

  localparam int unsigned EW = DW + FLAG_W;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  rx_flags_t     in_flags, out_flags;
  logic [EW-1:0] in_word, out_word, push_word;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          pop, room, push, hold_valid, ovr_evt;

  assign in_flags = '{brk: char_brk, ferr: char_ferr, perr: char_perr};
  assign in_word  = {in_flags, char_data};

  assign pop  = rd_en && (cnt != '0);
  assign room = (cnt != CW'(DEPTH)) || pop;

  rxbuf_hold #(.EW(EW)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_valid (char_valid),
    .char_word  (in_word),
    .room       (room),
    .push       (push),
    .push_word  (push_word),
    .hold_valid (hold_valid),
    .ovr_evt    (ovr_evt)
  );

  rxbuf_fifo #(.EW(EW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_word (push_word),
    .pop       (pop),
    .rd_word   (out_word),
    .cnt       (cnt),
    .cnt_nxt   (cnt_nxt)
  );

  rxbuf_status #(.DEPTH(DEPTH)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_nxt   (cnt_nxt),
    .ovr_evt   (ovr_evt),
    .clr_err   (clr_err),
    .rx_ready  (rx_ready),
    .fifo_full (fifo_full),
    .overrun   (overrun)
  );

  assign out_flags = rx_flags_t'(out_word[EW-1:DW]);
  assign rd_data   = out_word[DW-1:0];
  assign rd_brk    = out_flags.brk;
  assign rd_ferr   = out_flags.ferr;
  assign rd_perr   = out_flags.perr;

  assert_hold_only_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid |-> fifo_full);

  assert_empty_read_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rx_ready) |=> $stable(out_word));

  assert_ready_tracks_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready == (cnt != '0));

endmodule

// File: tb/rxbuf_top_tb.sv
`timescale 1ns/1ps
module rxbuf_top_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       char_valid, char_brk, char_ferr, char_perr, rd_en, clr_err;
  logic [7:0] char_data, rd_data;
  logic       rd_brk, rd_ferr, rd_perr, rx_ready, fifo_full, overrun;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  rxbuf_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .char_valid(char_valid), .char_data(char_data),
    .char_brk(char_brk), .char_ferr(char_ferr), .char_perr(char_perr),
    .rd_en(rd_en),
    .rd_data(rd_data), .rd_brk(rd_brk), .rd_ferr(rd_ferr), .rd_perr(rd_perr),
    .clr_err(clr_err),
    .rx_ready(rx_ready), .fifo_full(fifo_full), .overrun(overrun)
  );

  // Vector layout: [27] arrive, [26:16] char {brk,ferr,perr,data}, [15] read,
  // [14] clear, [13] exp rx_ready, [12] exp fifo_full, [11] exp overrun,
  // [10:0] exp read word {brk,ferr,perr,data}
  localparam int NV = 14;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 11'h011, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'h000}, // R6 first entry
    {1'b1, 11'h422, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'h000},
    {1'b1, 11'h233, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 11'h000}, // R5 third fills
    {1'b1, 11'h144, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 11'h000}, // R2 waits
    {1'b1, 11'h055, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 11'h000}, // R3 overrun
    {1'b0, 11'h000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 11'h011}, // R5 refill keeps full, R4
    {1'b0, 11'h000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 11'h422}, // R5 full drops, R4
    {1'b0, 11'h000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'h422}, // R4 clear
    {1'b1, 11'h066, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 11'h233}, // R7 read+move
    {1'b0, 11'h000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 11'h055}, // R3 waiting 0x144 dropped
    {1'b0, 11'h000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'h066}, // R6 empty after read
    {1'b0, 11'h000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'h066}, // R8 empty read
    {1'b1, 11'h777, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'h066}, // R1 all flags
    {1'b0, 11'h000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'h777}  // R1 flags returned
  };

  task automatic check(input string req, input string what,
                       input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [10:0] rd_word();
    return {rd_brk, rd_ferr, rd_perr, rd_data};
  endfunction

  task automatic step(input logic v, input logic [10:0] c,
                      input logic rd, input logic clr);
    char_valid = v;
    {char_brk, char_ferr, char_perr, char_data} = c;
    rd_en   = rd;
    clr_err = clr;
    @(posedge clk);
    @(negedge clk);
    char_valid = 1'b0;
    rd_en      = 1'b0;
    clr_err    = 1'b0;
  endtask

  task automatic check_status(input string req, input logic rdy,
                              input logic full, input logic ovr);
    check(req, "rx_ready",  11'(rx_ready),  11'(rdy));
    check(req, "fifo_full", 11'(fifo_full), 11'(full));
    check(req, "overrun",   11'(overrun),   11'(ovr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    char_valid = 1'b0; char_data = '0; char_brk = 1'b0; char_ferr = 1'b0;
    char_perr = 1'b0; rd_en = 1'b0; clr_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check_status("R9", 1'b0, 1'b0, 1'b0);
    check("R9", "rd_word", rd_word(), 11'h000);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][27], VEC[i][26:16], VEC[i][15], VEC[i][14]);
      check_status($sformatf("R1/R2/R3/R4/R5/R6/R7/R8 vec%0d", i),
                   VEC[i][13], VEC[i][12], VEC[i][11]);
      check($sformatf("R1/R3/R7/R8 vec%0d", i), "rd_word", rd_word(), VEC[i][10:0]);
    end

    // Directed: full depth plus waiting stage, read with arrival (R2, R7)
    step(1'b1, 11'h101, 1'b0, 1'b0);
    step(1'b1, 11'h202, 1'b0, 1'b0);
    step(1'b1, 11'h303, 1'b0, 1'b0);
    step(1'b1, 11'h404, 1'b0, 1'b0);
    check_status("R2", 1'b1, 1'b1, 1'b0);
    step(1'b1, 11'h505, 1'b1, 1'b0);
    check_status("R7", 1'b1, 1'b1, 1'b0);
    check("R7", "rd_word", rd_word(), 11'h101);
    // Overrun colliding with clear: set wins (R4), 0x505 discarded (R3)
    step(1'b1, 11'h606, 1'b0, 1'b1);
    check_status("R4", 1'b1, 1'b1, 1'b1);
    step(1'b0, 11'h000, 1'b1, 1'b0);
    check("R2", "rd_word", rd_word(), 11'h202);
    check_status("R5", 1'b1, 1'b1, 1'b1);
    step(1'b0, 11'h000, 1'b1, 1'b0);
    check("R2", "rd_word", rd_word(), 11'h303);
    check_status("R5", 1'b1, 1'b0, 1'b1);
    step(1'b0, 11'h000, 1'b1, 1'b0);
    check("R2", "rd_word", rd_word(), 11'h404);
    step(1'b0, 11'h000, 1'b1, 1'b0);
    check("R3", "rd_word", rd_word(), 11'h606);
    check_status("R6", 1'b0, 1'b0, 1'b1);

    // Directed: reset in mid-run clears everything (R9)
    step(1'b1, 11'h0AA, 1'b0, 1'b0);
    step(1'b1, 11'h0BB, 1'b1, 1'b0);
    #1 rst_n = 1'b0;
    #1;
    check_status("R9", 1'b0, 1'b0, 1'b0);
    check("R9", "rd_word", rd_word(), 11'h000);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 11'h000, 1'b1, 1'b0);
    check_status("R9", 1'b0, 1'b0, 1'b0);
    check("R9", "rd_word", rd_word(), 11'h000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule